// File: doc/BRIEF.md
# Coprocessor Response Sequencing Controller

This controller sits on the main-processor side of a coprocessor interface. It runs the dialogue while one coprocessor instruction executes. It asks for the coprocessor's response register to be read, and it takes back each returned primitive in decoded form: a type code plus the come-again (CA), pass-finished (PF), interrupt-allowed (IA) and direction (DR) flags. From that it decides whether to read again, end the instruction, service a pending interrupt, or wait for post-instruction exception processing. When the instruction ends it also decides whether a trace exception is due.

The rule for ending a dialogue depends on the trace state. With no trace pending, a general-category instruction ends on the first primitive with CA=0, so the coprocessor can finish its work in parallel. With trace-on-every-instruction active, the controller keeps polling until the coprocessor reports real completion. That way the trace is never taken before the coprocessor's work is finished. An interrupt serviced in the middle of the dialogue is requested with a ten-word mid-instruction frame size. The controller then waits for the handler to return before it reads again.

Top module: `cprs_sequencer`

## Requirements
- R1: The synchronous active-high reset holds every output low and returns the controller to idle. A primitive presented after reset, without a new start, produces no output activity.
- R2: A start pulse in idle latches the category and the trace bits and produces a one-cycle `respRead`. A new `respRead` is issued only for a re-read, and at most one of `respRead`, `irqReq` and `instrDone` is high in any cycle.
- R3: With no polling trace in force, a primitive with CA=0 ends a general-category dialogue with a one-cycle `instrDone`. The primitive may be null (type 000), transfer-status/scanPC (type 001) or generic (types 011 to 111).
- R4: A null primitive with CA=1 causes a re-read. If IA=1 and `irqPending` is high, an interrupt request comes before that re-read.
- R5: `irqReq` is a one-cycle pulse with `frameWords` equal to 10 in the same cycle. No `respRead` or `instrDone` follows until `irqReturn` is seen, and then one `respRead` follows.
- R6: With trace bits 10 on a general-category instruction, a null primitive with CA=0 and PF=0 causes a re-read. Any non-null primitive with CA=0 also causes a re-read. A null primitive with CA=0 and PF=1 ends the dialogue.
- R7: In the polling case of R6, a null primitive with CA=0, PF=0 and IA=1, while `irqPending` is high, requests an interrupt before the re-read.
- R8: A take-post-instruction-exception primitive (type 010) stops all reads. The dialogue ends one cycle after `excDone` is seen.
- R9: With trace bits 01 on a general-category instruction, `traceReq` comes with `instrDone` only if a type-001 primitive with DR=1 was received during that instruction.
- R10: `traceReq` is high only together with `instrDone`. Trace bits 00 and 11 never raise it. Trace bits 10 always raise it, for both categories.
- R11: A conditional-category dialogue ends on any CA=0 primitive whatever the trace bits, and trace bits 01 raise no trace for it. A generic primitive (types 011 to 111) with CA=1 is acknowledged with a re-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a coprocessor instruction (sampled in idle) |
| isGeneral | input | 1 | 1 = general category, 0 = conditional category |
| traceMode | input | 2 | Trace bits: 00 off, 01 change of flow, 10 every instruction, 11 off |
| respValid | input | 1 | One-cycle strobe: decoded primitive fields are valid |
| primType | input | PRIM_W | Primitive type: 000 null, 001 transfer SR/scanPC, 010 post-instruction exception, others generic |
| flagCa | input | 1 | Come-again flag of the primitive |
| flagPf | input | 1 | Pass-finished flag of the primitive |
| flagIa | input | 1 | Interrupts-allowed flag of the primitive |
| flagDr | input | 1 | Direction flag of the primitive |
| irqPending | input | 1 | An interrupt is pending in the main processor |
| irqReturn | input | 1 | Interrupt handler has returned |
| excDone | input | 1 | Post-instruction exception processing completed |
| respRead | output | 1 | Strobe: read the response register |
| irqReq | output | 1 | Strobe: service the pending interrupt now |
| frameWords | output | FRAME_W | Stack frame size in words, valid with irqReq |
| traceReq | output | 1 | Take a trace exception, valid with instrDone |
| instrDone | output | 1 | Strobe: the coprocessor instruction has ended |

## Verification
The checker assumes that the environment answers each read with exactly one one-cycle `respValid`, and never presents one when no read is outstanding. It also assumes that `irqReturn` comes only after an `irqReq`, and `excDone` only after a type-010 primitive. Its reads-held properties depend on these ordering assumptions. The bench keeps to them: the driver waits until it has seen `respRead` before it presents a primitive. It pulses `irqReturn` only after it has observed `irqReq`, and it raises `excDone` only after it has sent a post-instruction exception primitive. The one deliberate exception is a primitive sent after a reset cut the dialogue. That primitive tests R1 and is checked only at the ports.

// File: rtl/cprs_pkg.sv
package cprs_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_READ,
    SEQ_WAIT,
    SEQ_IRQ,
    SEQ_IRQWAIT,
    SEQ_EXC,
    SEQ_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    TRC_OFF   = 2'b00,
    TRC_FLOW  = 2'b01,
    TRC_EVERY = 2'b10,
    TRC_RSVD  = 2'b11
  } traceMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCtx;     // latch instruction context at start
    logic sampleResp;  // a primitive is being consumed this cycle
    logic frameSel;    // drive the interrupt frame size
  } ctlStrobe_t;

  // decode and context results from datapath to control
  typedef struct packed {
    logic isNull;
    logic isScan;
    logic isPostExc;
    logic pollToEnd;   // keep polling until PF=1 on a null primitive
    logic traceAtEnd;  // a trace is due when the instruction ends
  } dpStatus_t;

endpackage

// File: rtl/cprs_datapath.sv
module cprs_datapath
  import cprs_pkg::*;
#(
  parameter int PRIM_W       = 3,
  parameter int NULL_CODE    = 0,
  parameter int SCAN_CODE    = 1,
  parameter int POSTEXC_CODE = 2,
  parameter int FRAME_W      = 4,
  parameter int FRAME_WORDS  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic              isGeneral,
  input  logic [1:0]        traceMode,
  input  logic [PRIM_W-1:0] primType,
  input  logic              flagDr,
  output dpStatus_t         status,
  output logic [FRAME_W-1:0] frameWords
);

  localparam logic [PRIM_W-1:0] NullCode    = PRIM_W'(NULL_CODE);
  localparam logic [PRIM_W-1:0] ScanCode    = PRIM_W'(SCAN_CODE);
  localparam logic [PRIM_W-1:0] PostExcCode = PRIM_W'(POSTEXC_CODE);
  localparam logic [FRAME_W-1:0] FrameSize  = FRAME_W'(FRAME_WORDS);

  logic       ctxGeneral;
  traceMode_t ctxMode;
  logic       drSeen;
  logic       primIsScan;

  assign primIsScan = (primType == ScanCode);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctxGeneral <= 1'b0;
      ctxMode    <= TRC_OFF;
      drSeen     <= 1'b0;
    end else if (strobe.loadCtx) begin
      ctxGeneral <= isGeneral;
      ctxMode    <= traceMode_t'(traceMode);
      drSeen     <= 1'b0;
    end else if (strobe.sampleResp && primIsScan && flagDr) begin
      drSeen <= 1'b1;
    end
  end

  always_comb begin
    status.isNull     = (primType == NullCode);
    status.isScan     = primIsScan;
    status.isPostExc  = (primType == PostExcCode);
    status.pollToEnd  = ctxGeneral && (ctxMode == TRC_EVERY);
    status.traceAtEnd = (ctxMode == TRC_EVERY) ||
                        (ctxGeneral && (ctxMode == TRC_FLOW) && drSeen);
  end

  assign frameWords = strobe.frameSel ? FrameSize : '0;

endmodule

// File: rtl/cprs_control.sv
module cprs_control
  import cprs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       respValid,
  input  logic       flagCa,
  input  logic       flagPf,
  input  logic       flagIa,
  input  logic       irqPending,
  input  logic       irqReturn,
  input  logic       excDone,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       respRead,
  output logic       irqReq,
  output logic       instrDone,
  output logic       traceReq
);

  seqState_t state, nextState;
  logic      irqOk;

  assign irqOk = flagIa && irqPending;

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      SEQ_IDLE:    if (start) nextState = SEQ_READ;
      SEQ_READ:    nextState = SEQ_WAIT;
      SEQ_WAIT: begin
        if (respValid) begin
          if (status.isPostExc) begin
            nextState = SEQ_EXC;
          end else if (status.isNull) begin
            if (flagCa)                 nextState = irqOk ? SEQ_IRQ : SEQ_READ;
            else if (!status.pollToEnd) nextState = SEQ_DONE;
            else if (flagPf)            nextState = SEQ_DONE;
            else                        nextState = irqOk ? SEQ_IRQ : SEQ_READ;
          end else begin
            if (flagCa || status.pollToEnd) nextState = SEQ_READ;
            else                            nextState = SEQ_DONE;
          end
        end
      end
      SEQ_IRQ:     nextState = SEQ_IRQWAIT;
      SEQ_IRQWAIT: if (irqReturn) nextState = SEQ_READ;
      SEQ_EXC:     if (excDone) nextState = SEQ_DONE;
      SEQ_DONE:    nextState = SEQ_IDLE;
      default:     nextState = SEQ_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadCtx    = (state == SEQ_IDLE) && start;
    strobe.sampleResp = (state == SEQ_WAIT) && respValid;
    strobe.frameSel   = (state == SEQ_IRQ);
    respRead          = (state == SEQ_READ);
    irqReq            = (state == SEQ_IRQ);
    instrDone         = (state == SEQ_DONE);
    traceReq          = (state == SEQ_DONE) && status.traceAtEnd;
  end

endmodule

// File: rtl/cprs_sequencer.sv
module cprs_sequencer
  import cprs_pkg::*;
#(
  parameter int PRIM_W       = 3,
  parameter int NULL_CODE    = 0,
  parameter int SCAN_CODE    = 1,
  parameter int POSTEXC_CODE = 2,
  parameter int FRAME_W      = 4,
  parameter int FRAME_WORDS  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               isGeneral,
  input  logic [1:0]         traceMode,
  input  logic               respValid,
  input  logic [PRIM_W-1:0]  primType,
  input  logic               flagCa,
  input  logic               flagPf,
  input  logic               flagIa,
  input  logic               flagDr,
  input  logic               irqPending,
  input  logic               irqReturn,
  input  logic               excDone,
  output logic               respRead,
  output logic               irqReq,
  output logic [FRAME_W-1:0] frameWords,
  output logic               traceReq,
  output logic               instrDone
);

  ctlStrobe_t ctlStrobe;
  dpStatus_t  dpStatus;

  cprs_datapath #(
    .PRIM_W(PRIM_W), .NULL_CODE(NULL_CODE), .SCAN_CODE(SCAN_CODE),
    .POSTEXC_CODE(POSTEXC_CODE), .FRAME_W(FRAME_W), .FRAME_WORDS(FRAME_WORDS)
  ) i_datapath (
    .clk(clk), .rst(rst), .strobe(ctlStrobe), .isGeneral(isGeneral),
    .traceMode(traceMode), .primType(primType), .flagDr(flagDr),
    .status(dpStatus), .frameWords(frameWords)
  );

  cprs_control i_control (
    .clk(clk), .rst(rst), .start(start), .respValid(respValid),
    .flagCa(flagCa), .flagPf(flagPf), .flagIa(flagIa),
    .irqPending(irqPending), .irqReturn(irqReturn), .excDone(excDone),
    .status(dpStatus), .strobe(ctlStrobe), .respRead(respRead),
    .irqReq(irqReq), .instrDone(instrDone), .traceReq(traceReq)
  );

endmodule

// File: rtl/cprs_checker.sv
module cprs_checker #(
  parameter int PRIM_W       = 3,
  parameter int POSTEXC_CODE = 2,
  parameter int FRAME_W      = 4,
  parameter int FRAME_WORDS  = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               respRead,
  input logic               irqReq,
  input logic [FRAME_W-1:0] frameWords,
  input logic               instrDone,
  input logic               traceReq,
  input logic               irqReturn,
  input logic               respValid,
  input logic [PRIM_W-1:0]  primType,
  input logic               excDone
);

  logic waitIrq, awaitResp, waitExc;

  always_ff @(posedge clk) begin
    if (rst) begin
      waitIrq   <= 1'b0;
      awaitResp <= 1'b0;
      waitExc   <= 1'b0;
    end else begin
      if (irqReq)         waitIrq <= 1'b1;
      else if (irqReturn) waitIrq <= 1'b0;
      if (respRead)       awaitResp <= 1'b1;
      else if (respValid) awaitResp <= 1'b0;
      if (awaitResp && respValid && primType == PRIM_W'(POSTEXC_CODE)) waitExc <= 1'b1;
      else if (excDone)   waitExc <= 1'b0;
    end
  end

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    respRead |=> !respRead); // R2
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({respRead, irqReq, instrDone})); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    instrDone |=> !instrDone); // R3
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irqReq |=> !irqReq); // R5
  AST_IRQ_FRAME: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> frameWords == FRAME_W'(FRAME_WORDS)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    waitIrq |-> !respRead && !instrDone); // R5
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (rst)
    waitExc |-> !respRead); // R8
  AST_TRACE_AT_END: assert property (@(posedge clk) disable iff (rst)
    traceReq |-> instrDone); // R10

endmodule

bind cprs_sequencer cprs_checker #(
  .PRIM_W(PRIM_W), .POSTEXC_CODE(POSTEXC_CODE),
  .FRAME_W(FRAME_W), .FRAME_WORDS(FRAME_WORDS)
) i_checker (
  .clk(clk), .rst(rst), .respRead(respRead), .irqReq(irqReq),
  .frameWords(frameWords), .instrDone(instrDone), .traceReq(traceReq),
  .irqReturn(irqReturn), .respValid(respValid), .primType(primType),
  .excDone(excDone)
);

// File: tb/test_cprs_sequencer.sv
module test_cprs_sequencer;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       start = 1'b0, isGeneral = 1'b0;
  logic [1:0] traceMode = 2'b00;
  logic       respValid = 1'b0;
  logic [2:0] primType = 3'b000;
  logic       flagCa = 1'b0, flagPf = 1'b0, flagIa = 1'b0, flagDr = 1'b0;
  logic       irqPending = 1'b0, irqReturn = 1'b0, excDone = 1'b0;
  logic       respRead, irqReq, traceReq, instrDone;
  logic [3:0] frameWords;

  cprs_sequencer i_cprs_sequencer (
    .clk(clk), .rst(rst), .start(start), .isGeneral(isGeneral),
    .traceMode(traceMode), .respValid(respValid), .primType(primType),
    .flagCa(flagCa), .flagPf(flagPf), .flagIa(flagIa), .flagDr(flagDr),
    .irqPending(irqPending), .irqReturn(irqReturn), .excDone(excDone),
    .respRead(respRead), .irqReq(irqReq), .frameWords(frameWords),
    .traceReq(traceReq), .instrDone(instrDone)
  );

  localparam int EV_READ = 1, EV_IRQ = 2, EV_DONE = 3, EV_DONE_TRC = 4, EV_BAD = 5;

  typedef struct { int code; string req; } expItem_t;
  expItem_t expQ[$];
  int checks = 0, fails = 0, cycles = 0;

  function automatic string evName(int c);
    case (c)
      EV_READ:     return "READ";
      EV_IRQ:      return "IRQ(frame10)";
      EV_DONE:     return "DONE";
      EV_DONE_TRC: return "DONE+TRACE";
      EV_BAD:      return "MALFORMED";
      default:     return "NONE";
    endcase
  endfunction

  task automatic expectEv(int code, string req);
    expQ.push_back('{code, req});
  endtask

  // monitor: pops the scoreboard as events appear
  always @(negedge clk) begin
    int obs;
    expItem_t item;
    obs = 0;
    if (!rst) begin
      if (respRead)       obs = EV_READ;
      else if (irqReq)    obs = (frameWords == 4'd10) ? EV_IRQ : EV_BAD;
      else if (instrDone) obs = traceReq ? EV_DONE_TRC : EV_DONE;
      else if (traceReq)  obs = EV_BAD;
      if (obs != 0) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL unexpected event: actual %s expected none", evName(obs));
        end else begin
          item = expQ.pop_front();
          if (item.code != obs) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", item.req, evName(obs), evName(item.code));
          end
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic startInstr(bit gen, bit [1:0] mode);
    @(negedge clk);
    start = 1'b1; isGeneral = gen; traceMode = mode;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendPrim(bit [2:0] t, bit ca, bit pf, bit ia, bit dr);
    while (!respRead) @(negedge clk);
    @(negedge clk);
    respValid = 1'b1; primType = t; flagCa = ca; flagPf = pf; flagIa = ia; flagDr = dr;
    @(negedge clk);
    respValid = 1'b0; flagCa = 1'b0; flagPf = 1'b0; flagIa = 1'b0; flagDr = 1'b0;
  endtask

  task automatic serviceIrq();
    while (!irqReq) @(negedge clk);
    repeat (3) @(negedge clk);
    irqReturn = 1'b1;
    @(negedge clk);
    irqReturn = 1'b0;
  endtask

  task automatic finishExc();
    repeat (4) @(negedge clk);
    excDone = 1'b1;
    @(negedge clk);
    excDone = 1'b0;
  endtask

  task automatic waitDone();
    while (!instrDone) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkQuiet(string req);
    checks++;
    if (respRead || irqReq || instrDone || traceReq || frameWords != 4'd0) begin
      fails++;
      $display("FAIL %s: actual outputs %b%b%b%b/%0d expected 0000/0", req,
               respRead, irqReq, instrDone, traceReq, frameWords);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkQuiet("R1");                 // outputs low during reset
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checkQuiet("R1");                 // idle after reset

    // R2 R4 R11 R3: re-reads then end on CA=0, trace off
    expectEv(EV_READ, "R2"); startInstr(1, 2'b00);
    expectEv(EV_READ, "R4"); sendPrim(3'b000, 1, 0, 0, 0);
    expectEv(EV_READ, "R11"); sendPrim(3'b011, 1, 0, 0, 0);
    expectEv(EV_DONE, "R3"); sendPrim(3'b000, 0, 0, 0, 0);
    waitDone();

    // R3: scan primitive with CA=0 ends, generic CA=0 ends
    expectEv(EV_READ, "R2"); startInstr(1, 2'b00);
    expectEv(EV_DONE, "R3"); sendPrim(3'b001, 0, 0, 0, 0);
    waitDone();
    expectEv(EV_READ, "R2"); startInstr(1, 2'b00);
    expectEv(EV_DONE, "R3"); sendPrim(3'b110, 0, 0, 0, 0);
    waitDone();

    // R4 R5: interrupt on null CA=1 IA=1
    irqPending = 1'b1;
    expectEv(EV_READ, "R2"); startInstr(1, 2'b00);
    expectEv(EV_IRQ, "R4"); expectEv(EV_READ, "R5");
    sendPrim(3'b000, 1, 0, 1, 0); serviceIrq();
    expectEv(EV_READ, "R4"); sendPrim(3'b000, 1, 0, 0, 0);   // IA=0: no service
    irqPending = 1'b0;
    expectEv(EV_READ, "R4"); sendPrim(3'b000, 1, 0, 1, 0);   // nothing pending
    expectEv(EV_DONE, "R3"); sendPrim(3'b000, 0, 0, 0, 0);
    waitDone();

    // R6 R10: polling under trace-every
    expectEv(EV_READ, "R2"); startInstr(1, 2'b10);
    expectEv(EV_READ, "R6"); sendPrim(3'b000, 0, 0, 0, 0);
    expectEv(EV_READ, "R6"); sendPrim(3'b101, 0, 0, 0, 0);
    expectEv(EV_DONE_TRC, "R6"); sendPrim(3'b000, 0, 1, 0, 0);
    waitDone();

    // R7: interrupt while polling
    irqPending = 1'b1;
    expectEv(EV_READ, "R2"); startInstr(1, 2'b10);
    expectEv(EV_IRQ, "R7"); expectEv(EV_READ, "R7");
    sendPrim(3'b000, 0, 0, 1, 0); serviceIrq();
    irqPending = 1'b0;
    expectEv(EV_DONE_TRC, "R10"); sendPrim(3'b000, 0, 1, 0, 0);
    waitDone();

    // R8: post-instruction exception primitive
    expectEv(EV_READ, "R2"); startInstr(1, 2'b00);
    expectEv(EV_DONE, "R8"); sendPrim(3'b010, 0, 0, 0, 0); finishExc();
    waitDone();
    expectEv(EV_READ, "R2"); startInstr(1, 2'b10);
    expectEv(EV_DONE_TRC, "R8"); sendPrim(3'b010, 1, 0, 0, 0); finishExc();
    waitDone();

    // R9: trace on change of flow
    expectEv(EV_READ, "R2"); startInstr(1, 2'b01);
    expectEv(EV_READ, "R9"); sendPrim(3'b001, 1, 0, 0, 0);
    expectEv(EV_DONE, "R9"); sendPrim(3'b000, 0, 0, 0, 0);
    waitDone();
    expectEv(EV_READ, "R2"); startInstr(1, 2'b01);
    expectEv(EV_READ, "R9"); sendPrim(3'b001, 1, 0, 0, 1);
    expectEv(EV_DONE_TRC, "R9"); sendPrim(3'b000, 0, 0, 0, 0);
    waitDone();

    // R10: mode 11 is off
    expectEv(EV_READ, "R2"); startInstr(1, 2'b11);
    expectEv(EV_DONE, "R10"); sendPrim(3'b000, 0, 0, 0, 0);
    waitDone();

    // R11: conditional category
    expectEv(EV_READ, "R2"); startInstr(0, 2'b10);
    expectEv(EV_DONE_TRC, "R11"); sendPrim(3'b000, 0, 0, 0, 0);
    waitDone();
    expectEv(EV_READ, "R2"); startInstr(0, 2'b01);
    expectEv(EV_DONE, "R11"); sendPrim(3'b001, 0, 0, 0, 1);
    waitDone();

    // R1: reset mid-dialogue, then a stray primitive is ignored
    expectEv(EV_READ, "R2"); startInstr(1, 2'b00);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checkQuiet("R1");
    rst = 1'b0;
    @(negedge clk);
    respValid = 1'b1; primType = 3'b000;
    @(negedge clk);
    respValid = 1'b0;
    repeat (6) @(negedge clk);
    checkQuiet("R1");

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d events missing expected 0", expQ[0].req, expQ.size());
    end
    summary();
  end

endmodule